// File: doc/BRIEF.md
# Dual-Channel PWM Slice

A pulse-width generator with two output channels that share one counter. The counter advances only on enable ticks. A fractional divider produces these ticks, so the counter period can be set in steps of one sixteenth of a clock cycle. The counter runs in one of two modes. In edge-aligned mode it counts up and restarts at zero. In centre-aligned mode it climbs to the wrap value and descends again, which centres the pulse in the period whatever the duty cycle.

Each channel compares its own threshold with the shared counter. The channel is high while the threshold is strictly larger than the counter. Each channel has its own output inverter.

The wrap value, both thresholds and the mode are copied into working registers only at the end of a period. Software can therefore change them at any time without causing a truncated or doubled pulse. A one-cycle wrap strobe marks each period boundary.

Top module: `pwm_slice`

## Requirements
- R1: During and directly after reset the counter is 0, the wrap strobe is low, the working thresholds are 0, and so each pin shows its inversion setting (0 when not inverted).
- R2: `divVal` is unsigned 8.4 fixed point: bits [11:4] are the integer part and bits [3:0] are the fraction. The average spacing of counter ticks is divVal/16 clock cycles. An integer part of 0 stands for 256. Example: 0x018 gives 2 ticks every 3 cycles, and 0x000 gives one tick every 256 cycles.
- R3: With `phaseMode`=0 the counter runs 0,1,…,top and then returns to 0. The period is (top+1)·divVal/16 cycles.
- R4: With `phaseMode`=1 the counter runs up from 0 to top, holds top for one extra tick, runs down to 0, and holds 0 for one extra tick. The period is 2·(top+1)·divVal/16 cycles.
- R5: Before inversion, each channel is high exactly while its working threshold is strictly greater than the counter.
- R6: A threshold of 0 holds the channel low for the whole period. A threshold of top+1 or more holds it high for the whole period.
- R7: `invA` and `invB` each invert their own channel after the compare. The inversion takes effect in the same cycle, without waiting for a wrap.
- R8: While `enable` is low, the counter and divider do not move, no wrap strobe is produced, and neither pin changes.
- R9: `topVal`, `cmpA`, `cmpB` and `phaseMode` are copied into working registers only when a period ends. A change in mid-period does not alter the current period.
- R10: `wrapPulse` is high for exactly the one cycle after the tick that ends a period. In that cycle the counter has restarted at 0. Right after reset the working wrap value is 0, so the first tick ends a period and loads the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the divider and the counter |
| phaseMode | input | 1 | 1 selects centre-aligned up/down counting |
| divVal | input | 12 | Divider in 8.4 fixed point |
| topVal | input | 16 | Wrap value (buffered) |
| cmpA | input | 16 | Threshold for channel A (buffered) |
| cmpB | input | 16 | Threshold for channel B (buffered) |
| invA | input | 1 | Invert channel A |
| invB | input | 1 | Invert channel B |
| pwmA | output | 1 | Channel A pin |
| pwmB | output | 1 | Channel B pin |
| wrapPulse | output | 1 | One-cycle strobe at each period boundary |

## Verification
The bench builds the slice with the default 16-bit counter and the 8.4 divider format. It uses small wrap values (0 to 12) with integer divider parts of 1 to 3, so that many complete periods, mode changes and mid-period reloads fit in a short run.

Directed cases pin down specific behaviour: the 256 meaning of a zero integer part, the 1.5 fractional pattern, exact period lengths and high-time counts in both modes, and a wrap value shortened in mid-period. The randomised part is compared cycle by cycle with a behavioural model.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Strobes from the control module to the datapath (at most one per cycle)
  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic wrap;
  } pwm_strobe_t;
endpackage

// File: rtl/pwm_frac_div.sv
module pwm_frac_div #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      run,
  input  logic [INT_W+FRAC_W-1:0]   divVal,
  output logic                      fire
);
  localparam int DIV_W = INT_W + FRAC_W;
  localparam int EFF_W = DIV_W + 1;
  localparam int ACC_W = EFF_W + 1;
  localparam logic [ACC_W-1:0] UNIT = ACC_W'(1) << FRAC_W;

  logic [ACC_W-1:0] acc, sum, effDiv;
  logic intZero;

  // A zero integer part means 2^INT_W; its extra bit sits just above the field
  assign intZero = (divVal[DIV_W-1:FRAC_W] == '0);
  assign effDiv  = ACC_W'({intZero, divVal});
  assign sum     = acc + UNIT;
  assign fire    = run && (sum >= effDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acc <= '0;
    else if (run) acc <= fire ? (sum - effDiv) : sum;
  end

  // R8
  div_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> $stable(acc));
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        phaseAct,
  input  logic        atTop,
  input  logic        atZero,
  output pwm_strobe_t strb
);
  logic dirDown, flipDown;

  always_comb begin
    strb     = '0;
    flipDown = 1'b0;
    if (tick) begin
      if (!phaseAct) begin
        if (atTop) strb.wrap   = 1'b1;
        else       strb.stepUp = 1'b1;
      end else if (!dirDown) begin
        if (atTop) flipDown    = 1'b1;
        else       strb.stepUp = 1'b1;
      end else begin
        if (atZero) strb.wrap    = 1'b1;
        else        strb.stepDown = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          dirDown <= 1'b0;
    else if (strb.wrap) dirDown <= 1'b0;
    else if (flipDown)  dirDown <= 1'b1;
  end

  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.stepUp, strb.stepDown, strb.wrap}));

  // R4
  down_only_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepDown |-> phaseAct);
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwm_strobe_t      strb,
  input  logic [CNT_W-1:0] topIn,
  input  logic [CNT_W-1:0] cmpAIn,
  input  logic [CNT_W-1:0] cmpBIn,
  input  logic             phaseIn,
  input  logic             invA,
  input  logic             invB,
  output logic             atTop,
  output logic             atZero,
  output logic             phaseAct,
  output logic [CNT_W-1:0] cnt,
  output logic             pwmA,
  output logic             pwmB,
  output logic             wrapOut
);
  logic [CNT_W-1:0] topAct, cmpAAct, cmpBAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      topAct   <= '0;
      cmpAAct  <= '0;
      cmpBAct  <= '0;
      phaseAct <= 1'b0;
      wrapOut  <= 1'b0;
    end else begin
      wrapOut <= strb.wrap;
      if (strb.wrap) begin
        cnt      <= '0;
        topAct   <= topIn;
        cmpAAct  <= cmpAIn;
        cmpBAct  <= cmpBIn;
        phaseAct <= phaseIn;
      end else if (strb.stepUp) begin
        cnt <= cnt + 1'b1;
      end else if (strb.stepDown) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign atTop  = (cnt == topAct);
  assign atZero = (cnt == '0);
  assign pwmA   = (cmpAAct > cnt) ^ invA;
  assign pwmB   = (cmpBAct > cnt) ^ invB;

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= topAct);

  // R10
  wrap_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrap |=> (cnt == '0) && wrapOut);

  // R9
  top_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrap |=> $stable(topAct));
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
  import pwm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DIV_INT_W  = 8,
  parameter int DIV_FRAC_W = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          enable,
  input  logic                          phaseMode,
  input  logic [DIV_INT_W+DIV_FRAC_W-1:0] divVal,
  input  logic [CNT_W-1:0]              topVal,
  input  logic [CNT_W-1:0]              cmpA,
  input  logic [CNT_W-1:0]              cmpB,
  input  logic                          invA,
  input  logic                          invB,
  output logic                          pwmA,
  output logic                          pwmB,
  output logic                          wrapPulse
);
  pwm_strobe_t      strb;
  logic             fire, atTop, atZero, phaseAct;
  logic [CNT_W-1:0] cnt;

  pwm_frac_div #(.INT_W(DIV_INT_W), .FRAC_W(DIV_FRAC_W)) uDiv (
    .clk(clk), .rstN(rstN), .run(enable), .divVal(divVal), .fire(fire));

  pwm_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .tick(fire), .phaseAct(phaseAct),
    .atTop(atTop), .atZero(atZero), .strb(strb));

  pwm_datapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .topIn(topVal), .cmpAIn(cmpA),
    .cmpBIn(cmpB), .phaseIn(phaseMode), .invA(invA), .invB(invB),
    .atTop(atTop), .atZero(atZero), .phaseAct(phaseAct), .cnt(cnt),
    .pwmA(pwmA), .pwmB(pwmB), .wrapOut(wrapPulse));

  // R8
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(cnt) && !wrapPulse);
endmodule

// File: tb/tb_pwm_slice.sv
module tb_pwm_slice;
  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0, phaseMode = 1'b0;
  logic invA = 1'b0, invB = 1'b0;
  logic [11:0] divVal = 12'h010;
  logic [15:0] topVal = '0, cmpA = '0, cmpB = '0;
  logic pwmA, pwmB, wrapPulse;

  int checks = 0, fails = 0, cycles = 0;

  pwm_slice dut (.*);

  always #2.5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // Behavioural model of the requirements
  int mAcc, mCnt, mTop, mA, mB, eff, sum;
  bit mDown, mPh, mWrap, doWrap;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAcc = 0; mCnt = 0; mTop = 0; mA = 0; mB = 0;
      mDown = 0; mPh = 0; mWrap = 0;
    end else begin
      mWrap = 0;
      if (enable) begin
        eff = (divVal[11:4] == 0) ? 4096 + int'(divVal[3:0]) : int'(divVal);
        sum = mAcc + 16;
        if (sum >= eff) begin
          mAcc = sum - eff;
          doWrap = 0;
          if (!mPh) begin
            if (mCnt == mTop) doWrap = 1; else mCnt++;
          end else if (!mDown) begin
            if (mCnt == mTop) mDown = 1; else mCnt++;
          end else begin
            if (mCnt == 0) doWrap = 1; else mCnt--;
          end
          if (doWrap) begin
            mWrap = 1; mCnt = 0; mDown = 0; mTop = int'(topVal);
            mA = int'(cmpA); mB = int'(cmpB); mPh = phaseMode;
          end
        end else mAcc = sum;
      end
    end
  end

  task automatic waitWrap();
    do @(negedge clk); while (!wrapPulse);
  endtask

  // Called just after a wrap sample; counts one full period
  task automatic measure(output int period, output int hiA, output int hiB);
    period = 0; hiA = 0; hiB = 0;
    do begin
      @(negedge clk);
      period++;
      hiA += int'(pwmA);
      hiB += int'(pwmB);
    end while (!wrapPulse);
  endtask

  initial begin
    int p, ha, hb, p2, changes;
    logic lastA, lastB;
    void'($urandom(32'd2024));

    // R1 reset state, R7 inversion applies at once
    repeat (3) @(negedge clk);
    check("R1 pwmA in reset", pwmA, 0);
    check("R1 pwmB in reset", pwmB, 0);
    check("R1 wrap in reset", wrapPulse, 0);
    invA = 1'b1;
    @(negedge clk);
    check("R7 inverted A during reset", pwmA, 1);
    invA = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1 pwmA after reset", pwmA, 0);

    // Edge-aligned: top 9, divider 2.0
    topVal = 16'd9; cmpA = 16'd4; cmpB = 16'd10; divVal = 12'h020;
    enable = 1'b1;
    waitWrap(); waitWrap();
    @(negedge clk);
    check("R10 wrap one cycle wide", wrapPulse, 0);
    waitWrap();
    measure(p, ha, hb);
    check("R3 edge period", p, 20);
    check("R5 channel A high time", ha, 8);
    check("R6 threshold top+1 always high", hb, 20);

    // Centre-aligned
    phaseMode = 1'b1;
    waitWrap();
    measure(p, ha, hb);
    check("R4 centre period", p, 40);
    check("R4 centre high time A", ha, 16);

    // Zero threshold, and inversion
    phaseMode = 1'b0; cmpA = 16'd0;
    waitWrap();
    measure(p, ha, hb);
    check("R6 threshold 0 always low", ha, 0);
    invA = 1'b1; invB = 1'b1;
    measure(p, ha, hb);
    check("R7 inverted A", ha, 20);
    check("R7 inverted B", hb, 0);
    invA = 1'b0; invB = 1'b0; cmpA = 16'd4;

    // R9 wrap value changed mid-period
    waitWrap();
    p = 0;
    do begin
      @(negedge clk);
      p++;
      if (p == 3) topVal = 16'd4;
    end while (!wrapPulse);
    check("R9 current period unchanged", p, 20);
    measure(p, ha, hb);
    check("R9 new wrap value next period", p, 10);

    // R2 fractional divider 1.5, top 2
    divVal = 12'h018; topVal = 16'd2;
    waitWrap(); waitWrap();
    measure(p, ha, hb);
    measure(p2, ha, hb);
    check("R2 fractional two periods", p + p2, 9);

    // R2 zero integer part = 256
    divVal = 12'h000; topVal = 16'd0;
    waitWrap(); waitWrap();
    measure(p, ha, hb);
    check("R2 zero integer means 256", p, 256);

    // R8 enable low freezes everything
    divVal = 12'h010; topVal = 16'd7; cmpA = 16'd3; cmpB = 16'd6;
    waitWrap(); waitWrap();
    repeat (2) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    lastA = pwmA; lastB = pwmB; changes = 0;
    repeat (60) begin
      @(negedge clk);
      if (pwmA !== lastA || pwmB !== lastB || wrapPulse) changes++;
    end
    check("R8 frozen while disabled", changes, 0);
    enable = 1'b1;

    // Random configurations compared with the model every cycle
    for (int s = 0; s < 12; s++) begin
      int t;
      t = $urandom_range(0, 12);
      topVal = 16'(t);
      cmpA = 16'($urandom_range(0, t + 2));
      cmpB = 16'($urandom_range(0, t + 2));
      divVal = {8'($urandom_range(1, 3)), 4'($urandom_range(0, 15))};
      phaseMode = 1'($urandom_range(0, 1));
      invA = 1'($urandom_range(0, 1));
      invB = 1'($urandom_range(0, 1));
      for (int c = 0; c < 400; c++) begin
        enable = ($urandom_range(0, 9) != 0);
        if (c == 150) topVal = 16'($urandom_range(0, 12));
        @(negedge clk);
        check(mPh ? "R4 model match" : "R5 model match",
              {29'd0, pwmA, pwmB, wrapPulse},
              {29'd0, 1'((mA > mCnt) ^ invA), 1'((mB > mCnt) ^ invB), mWrap});
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule